// File: doc/BRIEF.md
# Serial EEPROM Boot Loader

This block fetches the entire contents of a 64-word by 16-bit serial configuration EEPROM as soon as reset is released. It talks to the EEPROM over a four-wire serial link: a select line, a bit clock, a command line out and a data line in. It issues one read command per word, in ascending address order, and keeps each word in a local array. Logic elsewhere in the chip can read that array through a combinational port indexed by word number.

When the load is complete, the block reports one of two outcomes. If word 0 reads as all zeros or all ones, no part is fitted, so the block raises an absent flag and leaves the station address at zero. Otherwise it builds a 48-bit station address from six consecutive EEPROM bytes and raises a valid flag. After either outcome, done goes high and everything stays frozen until the next reset.

A parameter sets the serial bit timing in system clocks. The default is a 5 us half period at 200 MHz.

Top module: `eeprom_boot_loader`

## Requirements
- R1: While rstN is low, and after it rises, eeCs, eeSk, done, macValid and absent are all low. The load then starts without any other input and ends with done high.
- R2: For each word, eeCs rises with eeSk low. Exactly 9 bits follow on eeDi: the read opcode 1, 1, 0, then the 6-bit word address, most significant bit first.
- R3: Each output bit is placed on eeDi while eeSk is low. eeSk then goes high for one half period and low again. eeDi does not change while eeSk is high, and eeSk never rises while eeCs is low.
- R4: After the address, 16 eeSk pulses clock in the data word, most significant bit first. eeDo is sampled at the end of each high half period.
- R5: eeCs falls only after eeSk has been low for a half period. Words 0 to 63 are each read once, in ascending order, for exactly 25 eeSk rising edges per word.
- R6: If word 0 equals 0x0000 or 0xFFFF, then absent is 1, macValid is 0 and macAddr is 0.
- R7: Otherwise absent is 0 and macValid is 1. Address byte k (k = 0..5) is EEPROM byte 20+k and sits at macAddr[47-8k -: 8]. EEPROM byte 2w is bits [7:0] of word w, and byte 2w+1 is bits [15:8].
- R8: After done, rdWord equals the word read from EEPROM address rdIdx, with no clock delay.
- R9: Once done is high, it stays high until reset. eeCs and eeSk stay low, and macAddr, macValid and absent do not change.
- R10: Each eeSk high phase lasts exactly HALF_CLKS system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; a load starts when it is released |
| eeDo | input | 1 | Serial data returned by the EEPROM |
| eeCs | output | 1 | EEPROM select |
| eeSk | output | 1 | Serial bit clock |
| eeDi | output | 1 | Serial command and address to the EEPROM |
| rdIdx | input | 6 | Word index for the array read port |
| rdWord | output | 16 | Stored word at rdIdx |
| macAddr | output | 48 | Station address, first byte in the top bits |
| macValid | output | 1 | Station address was taken from the EEPROM |
| absent | output | 1 | Word 0 showed that no EEPROM is fitted |
| done | output | 1 | Load finished; held until reset |

## Verification
The assertions assume that eeDo is settled by the end of every eeSk high phase. They make no assumption about it at other times. They also assume that rstN is low at the start, so the serial lines begin idle. The bench memory model only changes eeDo on the half clock right after a rising eeSk, so every sample falls well within that window. The scenarios set word 0 to a typical value, to each of the two blank patterns, and to the smallest non-blank value.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  localparam int ADDR_BITS = 6;
  localparam int WORD_BITS = 16;
  localparam int NUM_WORDS = 1 << ADDR_BITS;
  localparam int OP_BITS   = 3;
  localparam logic [OP_BITS-1:0] READ_OP = 3'b110;
  localparam int CMD_BITS  = OP_BITS + ADDR_BITS;

  typedef logic [ADDR_BITS-1:0] wordAddr_t;
  typedef logic [WORD_BITS-1:0] word_t;

  typedef enum logic [2:0] {
    ST_BOOT, ST_SEL, ST_OUT, ST_IN, ST_TAIL, ST_DESEL, ST_DONE
  } ldState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic      loadCmd;
    logic      shiftOut;
    logic      sampleIn;
    logic      storeWord;
    logic      finish;
    wordAddr_t addr;
  } strobe_t;
endpackage

// File: rtl/eep_ctrl.sv
`timescale 1ns/1ps
module eep_ctrl import eep_pkg::*; #(
  parameter int unsigned HALF_CLKS = 1000
) (
  input  logic    clk,
  input  logic    rstN,
  output logic    eeCs,
  output logic    eeSk,
  output strobe_t stb
);
  localparam int DIV_W = $clog2(HALF_CLKS + 1);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CLKS - 1);
  localparam logic [CNT_W-1:0] OUT_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] IN_LAST  = CNT_W'(WORD_BITS - 1);
  localparam wordAddr_t LAST_ADDR = wordAddr_t'(NUM_WORDS - 1);

  ldState_t         state, stateN;
  logic [DIV_W-1:0] divCnt;
  logic             highPh, highN;
  logic [CNT_W-1:0] bitCnt, bitN;
  wordAddr_t        wordIdx, wordN;
  logic             halfEnd;

  assign halfEnd = (divCnt == DIV_LAST);

  always_comb begin
    stateN   = state;
    highN    = highPh;
    bitN     = bitCnt;
    wordN    = wordIdx;
    stb      = '0;
    stb.addr = wordIdx;
    case (state)
      ST_BOOT: begin
        stateN      = ST_SEL;
        stb.loadCmd = 1'b1;
      end
      ST_SEL: if (halfEnd) begin
        stateN = ST_OUT;
        highN  = 1'b0;
        bitN   = '0;
      end
      ST_OUT: if (halfEnd) begin
        if (!highPh) highN = 1'b1;
        else begin
          highN        = 1'b0;
          stb.shiftOut = 1'b1;
          if (bitCnt == OUT_LAST) begin
            stateN = ST_IN;
            bitN   = '0;
          end else bitN = bitCnt + 1'b1;
        end
      end
      ST_IN: if (halfEnd) begin
        if (!highPh) highN = 1'b1;
        else begin
          highN        = 1'b0;
          stb.sampleIn = 1'b1;
          if (bitCnt == IN_LAST) begin
            stb.storeWord = 1'b1;
            stateN        = ST_TAIL;
          end else bitN = bitCnt + 1'b1;
        end
      end
      ST_TAIL: if (halfEnd) stateN = ST_DESEL;
      ST_DESEL: if (halfEnd) begin
        if (wordIdx == LAST_ADDR) begin
          stateN     = ST_DONE;
          stb.finish = 1'b1;
        end else begin
          wordN       = wordIdx + 1'b1;
          stb.loadCmd = 1'b1;
          stb.addr    = wordIdx + 1'b1;
          stateN      = ST_SEL;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_BOOT;
      divCnt  <= '0;
      highPh  <= 1'b0;
      bitCnt  <= '0;
      wordIdx <= '0;
    end else begin
      state   <= stateN;
      highPh  <= highN;
      bitCnt  <= bitN;
      wordIdx <= wordN;
      if (state == ST_BOOT || state == ST_DONE || halfEnd) divCnt <= '0;
      else divCnt <= divCnt + 1'b1;
    end
  end

  assign eeCs = (state == ST_SEL) || (state == ST_OUT) || (state == ST_IN) || (state == ST_TAIL);
  assign eeSk = highPh && ((state == ST_OUT) || (state == ST_IN));

  // high-phase length tracker for the timing check
  logic [DIV_W:0] skHighLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) skHighLen <= '0;
    else if (!eeSk) skHighLen <= '0;
    else skHighLen <= skHighLen + 1'b1;
  end

  AST_SK_HIGH_HALF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eeSk) |-> skHighLen == (DIV_W+1)'(HALF_CLKS)) else $error("sk high length"); // R10
  AST_SELECT_BEFORE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeCs) |-> !eeSk) else $error("cs rose with sk high"); // R2
endmodule

// File: rtl/eep_datapath.sv
`timescale 1ns/1ps
module eep_datapath import eep_pkg::*; #(
  parameter int unsigned MAC_BYTE_OFS = 20,
  parameter int unsigned MAC_BYTES    = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic                   eeDo,
  input  wordAddr_t              rdIdx,
  output logic                   eeDi,
  output word_t                  rdWord,
  output logic [8*MAC_BYTES-1:0] macAddr,
  output logic                   macValid,
  output logic                   absent,
  output logic                   done
);
  localparam int MAC_W = 8 * MAC_BYTES;

  logic [CMD_BITS-1:0] cmdShift;
  word_t               dataShift;
  word_t               capWord;
  word_t               wordMem [NUM_WORDS];
  logic                word0Blank;
  logic [MAC_W-1:0]    macFlat;

  assign capWord = {dataShift[WORD_BITS-2:0], eeDo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdShift   <= '0;
      dataShift  <= '0;
      word0Blank <= 1'b0;
    end else begin
      if (stb.loadCmd) cmdShift <= {READ_OP, stb.addr};
      else if (stb.shiftOut) cmdShift <= {cmdShift[CMD_BITS-2:0], 1'b0};
      if (stb.sampleIn) dataShift <= capWord;
      if (stb.storeWord && stb.addr == '0)
        word0Blank <= (capWord == '0) || (capWord == '1);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.storeWord) wordMem[stb.addr] <= capWord;
  end

  // address bytes picked from little-endian word storage
  for (genvar k = 0; k < MAC_BYTES; k++) begin : g_macByte
    localparam int BYTE_IDX = MAC_BYTE_OFS + k;
    localparam int WIDX     = BYTE_IDX / 2;
    if (BYTE_IDX % 2 == 0) begin : g_lo
      assign macFlat[MAC_W-1-8*k -: 8] = wordMem[WIDX][7:0];
    end else begin : g_hi
      assign macFlat[MAC_W-1-8*k -: 8] = wordMem[WIDX][15:8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      absent   <= 1'b0;
      macValid <= 1'b0;
      macAddr  <= '0;
    end else if (stb.finish) begin
      done     <= 1'b1;
      absent   <= word0Blank;
      macValid <= !word0Blank;
      macAddr  <= word0Blank ? '0 : macFlat;
    end
  end

  assign eeDi   = cmdShift[CMD_BITS-1];
  assign rdWord = wordMem[rdIdx];

  AST_ABSENT_MATCHES_WORD0: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (absent == ((wordMem[0] == '0) || (wordMem[0] == '1)))) else $error("absent flag"); // R6
  AST_VALID_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (macValid != absent)) else $error("valid/absent"); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done && $stable(macAddr) && $stable(absent) && $stable(macValid)) else $error("result moved"); // R9
  AST_STORE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeWord |-> stb.sampleIn) else $error("store without sample"); // R4
endmodule

// File: rtl/eeprom_boot_loader.sv
`timescale 1ns/1ps
module eeprom_boot_loader import eep_pkg::*; #(
  parameter int unsigned CLK_MHZ      = 200,
  parameter int unsigned HALF_US      = 5,
  parameter int unsigned HALF_CLKS    = CLK_MHZ * HALF_US,
  parameter int unsigned MAC_BYTE_OFS = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 eeDo,
  output logic                 eeCs,
  output logic                 eeSk,
  output logic                 eeDi,
  input  logic [ADDR_BITS-1:0] rdIdx,
  output logic [WORD_BITS-1:0] rdWord,
  output logic [47:0]          macAddr,
  output logic                 macValid,
  output logic                 absent,
  output logic                 done
);
  strobe_t stb;

  eep_ctrl #(.HALF_CLKS(HALF_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .eeCs(eeCs), .eeSk(eeSk), .stb(stb)
  );

  eep_datapath #(.MAC_BYTE_OFS(MAC_BYTE_OFS), .MAC_BYTES(6)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .eeDo(eeDo), .rdIdx(rdIdx),
    .eeDi(eeDi), .rdWord(rdWord), .macAddr(macAddr), .macValid(macValid),
    .absent(absent), .done(done)
  );

  AST_DI_STEADY_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    eeSk |-> $stable(eeDi)) else $error("di moved while sk high"); // R3
  AST_CS_DROP_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eeCs) |-> !$past(eeSk)) else $error("cs dropped too early"); // R5
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !eeCs && !eeSk) else $error("lines active after done"); // R9
endmodule

// File: tb/sim_eeprom_boot_loader.sv
`timescale 1ns/1ps
module sim_eeprom_boot_loader;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eeDo = 1'b0;
  logic        eeCs, eeSk, eeDi;
  logic [5:0]  rdIdx = '0;
  logic [15:0] rdWord;
  logic [47:0] macAddr;
  logic        macValid, absent, done;

  always #2.5 clk = ~clk;

  eeprom_boot_loader #(.HALF_CLKS(HALF)) u0 (
    .clk(clk), .rstN(rstN), .eeDo(eeDo), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi),
    .rdIdx(rdIdx), .rdWord(rdWord), .macAddr(macAddr), .macValid(macValid),
    .absent(absent), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] romImg [64];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural EEPROM and protocol monitor, evaluated each falling clock
  int   n, expAddr, wordsSeen, hiLen, halfErr, edgesAfterDone;
  logic [8:0] cmd;
  bit   prevSk, prevCs, prevDi;

  always @(negedge clk) begin
    if (!rstN) begin
      n = 0; expAddr = 0; wordsSeen = 0; hiLen = 0; halfErr = 0; edgesAfterDone = 0;
      cmd = '0; prevSk = 0; prevCs = 0; prevDi = 0; eeDo = 1'b0;
    end else begin
      if (eeSk && !prevSk) begin
        if (done) edgesAfterDone++;
        if (!eeCs) chk(1'b0, "R3 sk rose without cs", 64'(eeCs), 64'd1);
        else begin
          n++;
          if (n <= 9) cmd = {cmd[7:0], eeDi};
          else if (n <= 25) eeDo = romImg[cmd[5:0]][25 - n];
        end
      end
      if (eeSk && prevSk && (eeDi != prevDi))
        chk(1'b0, "R3 di changed while sk high", 64'(eeDi), 64'(prevDi));
      if (eeSk) hiLen++;
      else begin
        if (prevSk && hiLen != HALF) halfErr++;
        hiLen = 0;
      end
      if (!eeCs && prevCs) begin
        chk(n == 25 && cmd[8:6] == 3'b110 && cmd[5:0] == expAddr[5:0],
            "R2 R5 command bits and word order",
            {47'd0, cmd, 8'(n)}, {47'd0, 3'b110, expAddr[5:0], 8'd25});
        expAddr++; wordsSeen++; n = 0; cmd = '0;
      end
      prevSk = eeSk; prevCs = eeCs; prevDi = eeDi;
    end
  end

  task automatic runScenario(input int sc, input logic [15:0] w0);
    logic [47:0] expMac, snap;
    bit blank;
    int cyc;
    romImg[0] = w0;
    for (int i = 1; i < 64; i++)
      romImg[i] = 16'((i * 16'h1357) + (sc * 16'h0F0F) + 16'h2468) ^ 16'(i << 9);
    for (int k = 0; k < 6; k++) begin
      int b;
      b = 20 + k;
      expMac[47 - 8*k -: 8] = (b % 2) ? romImg[b/2][15:8] : romImg[b/2][7:0];
    end
    blank = (w0 == 16'h0000) || (w0 == 16'hFFFF);

    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk({eeCs, eeSk, done, macValid, absent} == 5'b0, "R1 reset state",
        64'({eeCs, eeSk, done, macValid, absent}), 64'd0);
    rstN = 1'b1;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R1 load completes", 64'(done), 64'd1);
    chk(wordsSeen == 64, "R5 words read once each", 64'(wordsSeen), 64'd64);
    chk(halfErr == 0, "R10 sk high half period", 64'(halfErr), 64'd0);
    chk(absent == blank, "R6 absent flag", 64'(absent), 64'(blank));
    chk(macValid == !blank, "R7 address valid flag", 64'(macValid), 64'(!blank));
    if (blank) chk(macAddr == 48'd0, "R6 no address taken", 64'(macAddr), 64'd0);
    else chk(macAddr == expMac, "R7 address bytes", 64'(macAddr), 64'(expMac));
    for (int i = 0; i < 64; i++) begin
      rdIdx = 6'(i);
      #1;
      chk(rdWord == romImg[i], "R4 R8 stored word", 64'(rdWord), 64'(romImg[i]));
    end
    snap = macAddr;
    repeat (40) @(negedge clk);
    chk(done && !eeCs && !eeSk && macAddr == snap && edgesAfterDone == 0,
        "R9 held after done", {15'd0, done, eeCs, eeSk, macAddr}, {15'd0, 3'b100, snap});
  endtask

  initial begin
    runScenario(0, 16'hA5C3);
    runScenario(1, 16'hFFFF);
    runScenario(2, 16'h0000);
    runScenario(3, 16'h0001);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule